// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Byte Receiver (Ultra-Fast Mode)

This block listens to the clock and data lines of a two-wire serial bus running in its unidirectional, write-only fast variant. It only observes the lines and has no output toward them. It therefore never pulls the data line low in any slot, and it never holds the clock low. Both lines pass through a synchronizer into the system clock domain. Bus data is sampled on each rising edge of the synchronized clock line. Transitions of the data line while the clock line is high mark the begin and end conditions of a transfer.

After a begin condition, the receiver compares the address header with its own address, set by the `own_addr` input. The header is either one byte for a 7-bit address or two bytes for a 10-bit address, chosen by `ten_bit_mode`. When the header matches and announces a write, every following byte is presented on `rx_data` together with a single-cycle `rx_valid` strobe. This continues until the next begin or end condition.

Every byte on the bus is followed by a ninth slot. The sender drives that slot high, and the receiver skips it whatever its value. A header that fails to match, or that announces a read, makes the receiver deaf to the bus until the next begin condition.

Top module: `ufm_write_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rx_valid` is 0 and `rx_data` is 0.
- R2: A falling data line while the clock line is high (begin condition) restarts header reception from its first bit, in any state, including in the middle of a byte (repeated begin).
- R3: A rising data line while the clock line is high (end condition) returns the receiver to idle. Clock pulses that come after it without a new begin condition produce no `rx_valid`.
- R4: In 7-bit mode (`ten_bit_mode`=0) the header byte is accepted when its seven first-sent bits equal `own_addr[6:0]`, MSB first, and its eighth bit (the direction bit) is 0.
- R5: A header whose direction bit is 1 is not accepted, and the bytes that follow it produce no strobe.
- R6: In 10-bit mode the first header byte must be 1,1,1,1,0, then `own_addr[9]`, `own_addr[8]`, then direction 0. The second header byte must equal `own_addr[7:0]`.
- R7: After any header mismatch no `rx_valid` occurs until the next begin condition.
- R8: Once a header is accepted, each data byte is shifted in MSB first on rising clock-line edges. The receiver pulses `rx_valid` for exactly one system cycle, with the byte on `rx_data`, after the eighth bit of that byte.
- R9: The value on the bus in the ninth slot after each byte has no effect on the bytes delivered.
- R10: Any number of data bytes may follow one accepted header, each giving one strobe. After a repeated begin condition the header is evaluated anew.
- R11: `rx_data` changes only in a cycle in which `rx_valid` is 1 and otherwise holds the last delivered byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as observed (asynchronous) |
| sda_in | input | 1 | Bus data line as observed (asynchronous) |
| ten_bit_mode | input | 1 | 1 selects the two-byte 10-bit address header |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| rx_valid | output | 1 | One-cycle strobe for each received data byte |
| rx_data | output | 8 | Last received data byte |

## Verification
The hardest states to reach from the ports are the ones where the header fails to match partway through. One case is a 10-bit header whose first byte matches but whose second byte does not. Another is a repeated begin condition that arrives right after an accepted data byte, before any end condition. In both cases the receiver must switch between delivering and ignoring bytes without an end condition in between.

The stimulus reaches these states in two ways. Directed frames chain accepted, rejected and read-direction headers back to back with repeated begin conditions. Randomly generated frames pick the address mode, the own address, whether the header matches, the direction bit, the number of bytes and the ninth-slot level. The bench predicts the delivered byte list for each frame from the header rules alone.

// File: rtl/ufmrx_pkg.sv
package ufmrx_pkg;
  localparam int BYTE_W   = 8;
  localparam int SLOTS    = BYTE_W + 1;
  localparam int CNT_W    = $clog2(SLOTS + 1);
  localparam int ADDR_W   = 10;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR1,
    PH_ADDR2,
    PH_DATA,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/ufmrx_sync.sv
module ufmrx_sync #(
  parameter int STAGES = 2,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ufmrx_cond.sv
module ufmrx_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ufmrx_frame.sv
module ufmrx_frame
  import ufmrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              ten_bit_mode,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output phase_t            phase,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FILL_IDX = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_in;
  logic              hdr7_ok, hdr10a_ok, hdr10b_ok, listening;

  assign byte_in   = {shreg[BYTE_W-2:0], sda_s};
  assign hdr7_ok   = (byte_in[7:1] == own_addr[6:0]) && !byte_in[0];
  assign hdr10a_ok = (byte_in[7:3] == TEN_BIT_TAG) &&
                     (byte_in[2:1] == own_addr[9:8]) && !byte_in[0];
  assign hdr10b_ok = (byte_in == own_addr[7:0]);
  assign listening = (phase == PH_ADDR1) || (phase == PH_ADDR2) ||
                     (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (start_det) begin
        phase   <= PH_ADDR1;
        bit_cnt <= '0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
      end else if (scl_rise && listening) begin
        if (bit_cnt == FILL_IDX) begin
          bit_cnt <= '0;
        end else begin
          shreg   <= byte_in;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            case (phase)
              PH_ADDR1: begin
                if (ten_bit_mode) phase <= hdr10a_ok ? PH_ADDR2 : PH_IGNORE;
                else              phase <= hdr7_ok   ? PH_DATA  : PH_IGNORE;
              end
              PH_ADDR2: phase <= hdr10b_ok ? PH_DATA : PH_IGNORE;
              PH_DATA: begin
                rx_valid <= 1'b1;
                rx_data  <= byte_in;
              end
              default: phase <= PH_IGNORE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/ufm_write_rx.sv
module ufm_write_rx
  import ufmrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ten_bit_mode,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  logic [1:0]       lines_s;
  logic             scl_rise, start_det, stop_det;
  phase_t           phase;
  logic [CNT_W-1:0] bit_cnt;

  ufmrx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );

  ufmrx_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .start_det(start_det), .stop_det(stop_det)
  );

  ufmrx_frame u_frame (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .start_det(start_det),
    .stop_det(stop_det), .sda_s(lines_s[0]), .ten_bit_mode(ten_bit_mode),
    .own_addr(own_addr), .rx_valid(rx_valid), .rx_data(rx_data),
    .phase(phase), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/ufmrx_chk.sv
module ufmrx_chk
  import ufmrx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              start_det,
  input logic              stop_det,
  input phase_t            phase,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && rx_data == '0));

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  // R2
  begin_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_ADDR1 && bit_cnt == '0));

  // R3
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> (phase == PH_IDLE));

  // R7
  ignore_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |=> !rx_valid);
endmodule

bind ufm_write_rx ufmrx_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
  .start_det(start_det), .stop_det(stop_det), .phase(phase), .bit_cnt(bit_cnt)
);

// File: tb/ufm_write_rx_test.sv
module ufm_write_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       ten = 1'b0;
  logic [9:0] own = 10'h000;
  logic       rx_valid;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] cap [0:63];
  int         ncap = 0;
  logic       prev_v = 1'b0;
  int         dbl = 0;

  logic [7:0] tx [0:7];
  logic [7:0] exp_last = 8'h00;

  always #4 clk = ~clk;

  ufm_write_rx uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .ten_bit_mode(ten),
    .own_addr(own), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && ncap < 64) begin
        cap[ncap] = rx_data;
        ncap++;
      end
      if (rx_valid && prev_v) dbl++;
      prev_v = rx_valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_begin();
    scl = 1'b0; tick(4);
    sda = 1'b1; tick(4);
    scl = 1'b1; tick(4);
    sda = 1'b0; tick(4);
    scl = 1'b0; tick(4);
  endtask

  task automatic bus_end();
    scl = 1'b0; tick(4);
    sda = 1'b0; tick(4);
    scl = 1'b1; tick(4);
    sda = 1'b1; tick(6);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic fill);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; sda = b[i]; tick(4);
      scl = 1'b1; tick(4);
    end
    scl = 1'b0; sda = fill; tick(4);
    scl = 1'b1; tick(4);
    scl = 1'b0; tick(4);
  endtask

  function automatic bit hdr_ok(input bit t, input logic [9:0] o,
                                input logic [7:0] h0, input logic [7:0] h1);
    if (t) return (h0[7:3] == 5'b11110) && (h0[2:1] == o[9:8]) && !h0[0] && (h1 == o[7:0]);
    return (h0[7:1] == o[6:0]) && !h0[0];
  endfunction

  // full frame: begin, header, nb data bytes from tx[], optional end
  task automatic frame(input logic [7:0] h0, input logic [7:0] h1, input int nb,
                       input logic fill, input bit do_end, input string req);
    bit acc;
    int base;
    base = ncap;
    acc = hdr_ok(ten, own, h0, h1);
    bus_begin();
    put_byte(h0, fill);
    if (ten) put_byte(h1, fill);
    for (int k = 0; k < nb; k++) put_byte(tx[k], fill);
    if (do_end) bus_end(); else tick(6);
    check(dbl == 0, {req, " R8 single-cycle strobe"}, dbl, 0);
    check((ncap - base) == (acc ? nb : 0), {req, " strobe count"}, ncap - base, acc ? nb : 0);
    if (acc) begin
      for (int k = 0; k < nb; k++)
        check(cap[base + k] == tx[k], {req, " R8 byte value"}, cap[base + k], tx[k]);
      exp_last = tx[nb - 1];
    end
    check(rx_data == exp_last, "R11 rx_data holds last byte", rx_data, exp_last);
    if (ncap > 48) ncap = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    tick(5);
    check(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
    check(rx_data == 8'h00, "R1 reset rx_data", rx_data, 0);
    rst = 1'b0;
    tick(5);
    check(rx_valid == 1'b0 && rx_data == 8'h00, "R1 after reset", rx_data, 0);

    // R4 7-bit accepted, one byte
    ten = 1'b0; own = 10'h05A;
    tx[0] = 8'hC3;
    frame({7'h5A, 1'b0}, 8'h00, 1, 1'b1, 1, "R4");
    // R10 several bytes under one header
    tx[0] = 8'h01; tx[1] = 8'h80; tx[2] = 8'hFF;
    frame({7'h5A, 1'b0}, 8'h00, 3, 1'b1, 1, "R10");
    // R7 7-bit mismatch
    tx[0] = 8'h77;
    frame({7'h5B, 1'b0}, 8'h00, 2, 1'b1, 1, "R7");
    // R5 read direction
    frame({7'h5A, 1'b1}, 8'h00, 2, 1'b1, 1, "R5");
    // R9 ninth slot low
    tx[0] = 8'hA5; tx[1] = 8'h3C;
    frame({7'h5A, 1'b0}, 8'h00, 2, 1'b0, 1, "R9");
    // R6 10-bit accepted
    ten = 1'b1; own = 10'h2B7;
    tx[0] = 8'h5E; tx[1] = 8'h00;
    frame({5'b11110, 2'b10, 1'b0}, 8'hB7, 2, 1'b1, 1, "R6");
    // R6 second header byte wrong
    frame({5'b11110, 2'b10, 1'b0}, 8'hB6, 2, 1'b1, 1, "R6 low byte");
    // R6 bad tag
    frame({5'b11100, 2'b10, 1'b0}, 8'hB7, 1, 1'b1, 1, "R6 tag");
    // R2 repeated begin chain: accept, reject, accept
    tx[0] = 8'h11; tx[1] = 8'h22;
    frame({5'b11110, 2'b10, 1'b0}, 8'hB7, 2, 1'b1, 0, "R2 first");
    tx[0] = 8'h99;
    frame({5'b11110, 2'b11, 1'b0}, 8'hB7, 1, 1'b1, 0, "R2 reject");
    tx[0] = 8'h44;
    frame({5'b11110, 2'b10, 1'b0}, 8'hB7, 1, 1'b1, 1, "R2 reaccept");
    // R2 begin in the middle of a byte
    ten = 1'b0;
    tx[0] = 8'h6D;
    bus_begin();
    put_byte({7'h5A, 1'b0}, 1'b1);
    for (int i = 0; i < 4; i++) begin
      scl = 1'b0; sda = i[0]; tick(4); scl = 1'b1; tick(4);
    end
    frame({7'h5A, 1'b0}, 8'h00, 1, 1'b1, 1, "R2 mid-byte");
    // R3 clocks after end, no begin
    begin
      int base;
      base = ncap;
      put_byte(8'h5A << 0, 1'b1);
      put_byte(8'hF0, 1'b1);
      tick(6);
      check(ncap == base, "R3 no strobe after end", ncap - base, 0);
      check(rx_data == exp_last, "R3 rx_data unchanged", rx_data, exp_last);
    end

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [9:0] a;
      logic       rw, fl;
      int         nb;
      logic [7:0] h0, h1;
      ten = $urandom % 2;
      own = 10'($urandom);
      a   = ($urandom % 2) ? own : 10'($urandom);
      rw  = (($urandom % 5) == 0);
      fl  = $urandom % 2;
      nb  = 1 + ($urandom % 4);
      for (int k = 0; k < nb; k++) tx[k] = 8'($urandom);
      if (ten) begin h0 = {5'b11110, a[9:8], rw}; h1 = a[7:0]; end
      else     begin h0 = {a[6:0], rw};           h1 = 8'h00;  end
      frame(h0, h1, nb, fl, ($urandom % 3) != 0, "R10 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule